// File: doc/BRIEF.md
# Half-Duplex Command/Reply Serial Master

This block is a serial master for the half-duplex command/reply protocol known as MICROWIRE. Software-side logic queues 8-bit command bytes in a small transmit FIFO. For each command the engine pulls its active-low select line low. It shifts the command out MSB first, leaves one serial-clock period idle so the target can decode, and then clocks in a reply of 4 to 16 bits. The reply lands, right-aligned, in a receive FIFO.

The serial clock is made from the system clock with a programmable even divider, and it idles low. In single mode every frame is closed by raising the select line. In continuous mode frames follow one another with the select held low, for as long as commands are waiting. Each half of the serial clock lasts `cfgDivide/2` system clocks. Output data changes on the falling edge and input data is sampled on the rising edge.

Top module: `uwire_master`

## Requirements
- R1: While no frame is active, `sclk` is low and `fssN` is high; after reset both FIFOs report empty and not full.
- R2: A frame starts only when the transmit FIFO holds a byte. `fssN` falls and the oldest queued byte becomes the command, so commands go out in push order.
- R3: The command occupies the first 8 rising edges of `sclk` in a frame, MSB first. `txLine` changes only while `sclk` is low, and it is 0 outside the command bits.
- R4: `rxLine` is not sampled during the 8 command bits or during the wait period.
- R5: Exactly one `sclk` period (the 9th rising edge) separates the command LSB from the first reply bit, which is sampled on the 10th rising edge.
- R6: The reply length comes from `cfgReplyLen`, which is latched at frame start. Values below 4 act as 4 and values above 16 act as 16. The reply is received MSB first and stored right-aligned and zero-extended in `rxData`.
- R7: The `sclk` period is `cfgDivide` system clocks, half low and half high. The first rising edge comes `cfgDivide/2` clocks after `fssN` falls, and `sclk` toggles only while `fssN` is low.
- R8: When a frame closes, `fssN` rises exactly one `sclk` period after the last reply bit is sampled, with `sclk` low. The reply word is in the receive FIFO by then.
- R9: With `cfgContinuous`=1 and a command queued, `fssN` stays low. The next command MSB is sampled one `sclk` period after the previous reply LSB, and the reply is pushed on the falling edge between them.
- R10: With `cfgContinuous`=1 and the transmit FIFO empty at the end of a reply, the frame closes exactly as in single mode.
- R11: Each FIFO holds 8 entries. A push while full is dropped, and a pop while empty has no effect. Full and empty are never both set, and `rxData` shows the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgDivide | input | DIV_W | Serial clock period in system clocks (even, at least 2) |
| cfgReplyLen | input | LEN_W | Reply width in bits, 4 to MAX_REPLY |
| cfgContinuous | input | 1 | 1 = chain frames while commands are queued |
| txPush | input | 1 | Write one command byte |
| txData | input | 8 | Command byte to queue |
| txFull | output | 1 | Transmit FIFO full |
| txEmpty | output | 1 | Transmit FIFO empty |
| rxPop | input | 1 | Remove the oldest reply |
| rxData | output | MAX_REPLY | Oldest reply, right-aligned |
| rxFull | output | 1 | Receive FIFO full |
| rxEmpty | output | 1 | Receive FIFO empty |
| sclk | output | 1 | Serial clock |
| fssN | output | 1 | Active-low frame select |
| txLine | output | 1 | Serial data to the target |
| rxLine | input | 1 | Serial data from the target |

## Verification
The bench keeps the default build (MAX_REPLY=16, FIFO_DEPTH=8, DIV_W=8) and moves the divider between 2, 4 and 6. That covers a one-clock half period, where every serial edge meets a state change, as well as multi-clock halves. The 16-bit reply width lets one run cover the minimum, mid and maximum reply lengths, plus clamping from both sides. The 8-deep FIFOs are small enough to fill both of them within a single burst of ten commands, so the dropped-push paths are reached on each side.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  // Strobes from the sequencer to the datapath, valid for one system clock.
  typedef struct packed {
    logic loadTx;    // pop the next command into the shifter
    logic shiftTx;   // advance the command shifter (serial falling edge)
    logic clearRx;   // start a fresh reply word
    logic sampleRx;  // take rxLine into the reply shifter (serial rising edge)
    logic pushRx;    // store the finished reply word
    logic driveCmd;  // level: command bits are on the line
  } uwire_strobe_t;
endpackage

// File: rtl/uwire_fifo.sv
module uwire_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = store[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/uwire_datapath.sv
module uwire_datapath
  import uwire_pkg::*;
#(
  parameter int CMD_W      = 8,
  parameter int MAX_REPLY  = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  uwire_strobe_t        st,
  input  logic                 txPush,
  input  logic [CMD_W-1:0]     txData,
  output logic                 txFull,
  output logic                 txEmpty,
  input  logic                 rxPop,
  output logic [MAX_REPLY-1:0] rxData,
  output logic                 rxFull,
  output logic                 rxEmpty,
  input  logic                 rxLine,
  output logic                 txLine
);
  logic [CMD_W-1:0]     txHead;
  logic [CMD_W-1:0]     cmdShift;
  logic [MAX_REPLY-1:0] replyShift;

  uwire_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH)) txQueue (
    .clk(clk), .rstN(rstN),
    .push(txPush), .pushData(txData),
    .pop(st.loadTx), .popData(txHead),
    .full(txFull), .empty(txEmpty)
  );

  uwire_fifo #(.WIDTH(MAX_REPLY), .DEPTH(FIFO_DEPTH)) rxQueue (
    .clk(clk), .rstN(rstN),
    .push(st.pushRx), .pushData(replyShift),
    .pop(rxPop), .popData(rxData),
    .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdShift   <= '0;
      replyShift <= '0;
    end else begin
      if (st.loadTx)       cmdShift <= txHead;
      else if (st.shiftTx) cmdShift <= {cmdShift[CMD_W-2:0], 1'b0};
      if (st.clearRx)       replyShift <= '0;
      else if (st.sampleRx) replyShift <= {replyShift[MAX_REPLY-2:0], rxLine};
    end
  end

  assign txLine = st.driveCmd && cmdShift[CMD_W-1];
endmodule

// File: rtl/uwire_control.sv
module uwire_control
  import uwire_pkg::*;
#(
  parameter int CMD_W     = 8,
  parameter int MIN_REPLY = 4,
  parameter int MAX_REPLY = 16,
  parameter int DIV_W     = 8,
  parameter int LEN_W     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgDivide,
  input  logic [LEN_W-1:0] cfgReplyLen,
  input  logic             cfgContinuous,
  input  logic             txEmpty,
  output uwire_strobe_t    st,
  output logic             sclk,
  output logic             fssN
);
  localparam int SLOT_W = $clog2(CMD_W + MAX_REPLY + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} phase_t;

  phase_t           state;
  logic [DIV_W-1:0] halfCnt, halfLen, halfCalc;
  logic [LEN_W-1:0] replyLen, lenCalc;
  logic [SLOT_W-1:0] slot, lastSlot;
  logic             highHalf, tick, chain, atLast;

  always_comb begin
    halfCalc = DIV_W'(cfgDivide >> 1);
    if (halfCalc == '0) halfCalc = DIV_W'(1);
    if (cfgReplyLen < LEN_W'(MIN_REPLY))      lenCalc = LEN_W'(MIN_REPLY);
    else if (cfgReplyLen > LEN_W'(MAX_REPLY)) lenCalc = LEN_W'(MAX_REPLY);
    else                                      lenCalc = cfgReplyLen;
  end

  assign tick     = (halfCnt == halfLen - 1'b1);
  assign lastSlot = SLOT_W'(CMD_W) + SLOT_W'(replyLen);
  assign atLast   = (slot == lastSlot);
  assign chain    = cfgContinuous && !txEmpty;

  always_comb begin
    st = '0;
    st.driveCmd = (state == ST_RUN) && (slot < SLOT_W'(CMD_W));
    case (state)
      ST_IDLE: if (!txEmpty) begin
        st.loadTx  = 1'b1;
        st.clearRx = 1'b1;
      end
      ST_RUN: if (tick) begin
        if (!highHalf) begin
          st.sampleRx = (slot > SLOT_W'(CMD_W));
        end else if (atLast) begin
          if (chain) begin
            st.pushRx  = 1'b1;
            st.loadTx  = 1'b1;
            st.clearRx = 1'b1;
          end
        end else begin
          st.shiftTx = (slot < SLOT_W'(CMD_W));
        end
      end
      ST_TAIL: st.pushRx = tick;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sclk     <= 1'b0;
      fssN     <= 1'b1;
      halfCnt  <= '0;
      halfLen  <= DIV_W'(1);
      replyLen <= LEN_W'(MIN_REPLY);
      slot     <= '0;
      highHalf <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          sclk <= 1'b0;
          if (!txEmpty) begin
            fssN     <= 1'b0;
            state    <= ST_RUN;
            slot     <= '0;
            highHalf <= 1'b0;
            halfCnt  <= '0;
            halfLen  <= halfCalc;
            replyLen <= lenCalc;
          end
        end
        ST_RUN: begin
          if (tick) begin
            halfCnt <= '0;
            if (!highHalf) begin
              sclk     <= 1'b1;
              highHalf <= 1'b1;
            end else begin
              sclk     <= 1'b0;
              highHalf <= 1'b0;
              if (!atLast)    slot  <= slot + 1'b1;
              else if (chain) slot  <= '0;
              else            state <= ST_TAIL;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            halfCnt <= '0;
            fssN    <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uwire_master.sv
module uwire_master
  import uwire_pkg::*;
#(
  parameter int MAX_REPLY  = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8,
  localparam int CMD_W     = 8,
  localparam int MIN_REPLY = 4,
  localparam int LEN_W     = $clog2(MAX_REPLY + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DIV_W-1:0]     cfgDivide,
  input  logic [LEN_W-1:0]     cfgReplyLen,
  input  logic                 cfgContinuous,
  input  logic                 txPush,
  input  logic [CMD_W-1:0]     txData,
  output logic                 txFull,
  output logic                 txEmpty,
  input  logic                 rxPop,
  output logic [MAX_REPLY-1:0] rxData,
  output logic                 rxFull,
  output logic                 rxEmpty,
  output logic                 sclk,
  output logic                 fssN,
  output logic                 txLine,
  input  logic                 rxLine
);
  uwire_strobe_t strobes;

  uwire_control #(
    .CMD_W(CMD_W), .MIN_REPLY(MIN_REPLY), .MAX_REPLY(MAX_REPLY),
    .DIV_W(DIV_W), .LEN_W(LEN_W)
  ) sequencer (
    .clk(clk), .rstN(rstN),
    .cfgDivide(cfgDivide), .cfgReplyLen(cfgReplyLen),
    .cfgContinuous(cfgContinuous), .txEmpty(txEmpty),
    .st(strobes), .sclk(sclk), .fssN(fssN)
  );

  uwire_datapath #(
    .CMD_W(CMD_W), .MAX_REPLY(MAX_REPLY), .FIFO_DEPTH(FIFO_DEPTH)
  ) datapath (
    .clk(clk), .rstN(rstN), .st(strobes),
    .txPush(txPush), .txData(txData), .txFull(txFull), .txEmpty(txEmpty),
    .rxPop(rxPop), .rxData(rxData), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxLine(rxLine), .txLine(txLine)
  );
endmodule

// File: rtl/uwire_master_checker.sv
module uwire_master_checker (
  input logic clk,
  input logic rstN,
  input logic sclk,
  input logic fssN,
  input logic txLine,
  input logic txEmpty,
  input logic txFull,
  input logic rxFull,
  input logic rxPop
);
  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    fssN |-> !sclk);

  assert_frame_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fssN) |-> $past(!txEmpty));

  assert_cmd_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(txLine));

  assert_sclk_framed_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> !fssN);

  assert_close_clk_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fssN) |-> (!sclk && !$past(sclk)));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !rxPop) |=> rxFull);

  assert_tx_flags_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(txFull && txEmpty));
endmodule

bind uwire_master uwire_master_checker checker_inst (
  .clk(clk), .rstN(rstN), .sclk(sclk), .fssN(fssN), .txLine(txLine),
  .txEmpty(txEmpty), .txFull(txFull), .rxFull(rxFull), .rxPop(rxPop)
);

// File: tb/uwire_master_test.sv
`timescale 1ns/1ps
module uwire_master_test;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgDivide = 8'd4;
  logic [4:0]  cfgReplyLen = 5'd8;
  logic        cfgContinuous = 1'b0;
  logic        txPush = 1'b0;
  logic [7:0]  txData = '0;
  logic        txFull, txEmpty, rxFull, rxEmpty;
  logic        rxPop = 1'b0;
  logic [15:0] rxData;
  logic        sclk, fssN, txLine;
  logic        rxLine = 1'b1;

  uwire_master uut (
    .clk(clk), .rstN(rstN), .cfgDivide(cfgDivide), .cfgReplyLen(cfgReplyLen),
    .cfgContinuous(cfgContinuous), .txPush(txPush), .txData(txData),
    .txFull(txFull), .txEmpty(txEmpty), .rxPop(rxPop), .rxData(rxData),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .sclk(sclk), .fssN(fssN),
    .txLine(txLine), .rxLine(rxLine)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] replyOf(input logic [7:0] c, input int n);
    logic [15:0] v;
    v = {c, ~c} ^ 16'h3C5A;
    return v & 16'((32'd1 << n) - 1);
  endfunction

  // Target model and wire monitor
  int   effN = 8;
  int   cyc = 0;
  int   riseCnt = 0;
  int   lastRise = 0;
  int   fallCyc = 0;
  bit   firstRise = 1'b0;
  bit   prevSclk = 1'b0;
  bit   prevFss = 1'b1;
  logic [7:0] cmdAcc = '0;
  logic [7:0] cmdLog [16];
  int   nLog = 0;
  int   fssFalls = 0;
  int   fssRises = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (rstN) begin
      if (fssN && sclk) check(1'b0, "R1", "sclk high while idle", 1, 0);
      if (prevFss && !fssN) begin
        fssFalls++;
        fallCyc = cyc;
        firstRise = 1'b1;
        riseCnt = 0;
      end
      if (!prevFss && fssN) begin
        fssRises++;
        check(cyc - lastRise == int'(cfgDivide), "R8", "close delay",
              cyc - lastRise, int'(cfgDivide));
        check(riseCnt == 0, "R8", "rising edges left over", riseCnt, 0);
      end
      if (!prevSclk && sclk) begin
        if (firstRise)
          check(cyc - fallCyc == int'(cfgDivide) / 2, "R7", "first edge delay",
                cyc - fallCyc, int'(cfgDivide) / 2);
        else
          check(cyc - lastRise == int'(cfgDivide), "R7", "sclk period",
                cyc - lastRise, int'(cfgDivide));
        firstRise = 1'b0;
        lastRise = cyc;
        if (riseCnt < 8) cmdAcc = {cmdAcc[6:0], txLine};
        riseCnt++;
        if (riseCnt == 9 + effN) begin
          if (nLog < 16) cmdLog[nLog] = cmdAcc;
          nLog++;
          riseCnt = 0;
        end
      end
      if (prevSclk && !sclk) begin
        if (riseCnt >= 9 && riseCnt < 9 + effN) begin
          logic [15:0] rv;
          rv = replyOf(cmdAcc, effN);
          rxLine = rv[effN - 1 - (riseCnt - 9)];
        end else begin
          rxLine = 1'b1;  // junk during command and wait slots (R4)
        end
      end
    end
    prevSclk = sclk;
    prevFss = fssN;
  end

  task automatic configure(input int div, input int n, input bit cont);
    @(negedge clk);
    cfgDivide = 8'(div);
    cfgReplyLen = 5'(n);
    cfgContinuous = cont;
    effN = (n < 4) ? 4 : (n > 16) ? 16 : n;
    nLog = 0;
    fssFalls = 0;
    fssRises = 0;
  endtask

  task automatic pushCmd(input logic [7:0] c);
    @(negedge clk);
    txPush = 1'b1;
    txData = c;
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic popWord(input logic [15:0] exp, input string req);
    @(negedge clk);
    check(!rxEmpty, req, "reply present", int'(rxEmpty), 0);
    check(rxData == exp, req, "reply word", int'(rxData), int'(exp));
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  task automatic waitFrames(input int k);
    while (!(nLog >= k && fssN)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(sclk == 1'b0, "R1", "sclk after reset", int'(sclk), 0);
    check(fssN == 1'b1, "R1", "fssN after reset", int'(fssN), 1);
    check(txEmpty && !txFull, "R1", "tx flags after reset", {txFull, txEmpty}, 1);
    check(rxEmpty && !rxFull, "R1", "rx flags after reset", {rxFull, rxEmpty}, 1);
  endtask

  // One single-mode frame: R2 R3 R4 R5 R6 R8
  task automatic testSingle(input int div, input int n, input logic [7:0] c);
    configure(div, n, 1'b0);
    pushCmd(c);
    waitFrames(1);
    check(nLog == 1, "R2", "frame count", nLog, 1);
    check(cmdLog[0] == c, "R3", "command on wire", int'(cmdLog[0]), int'(c));
    check(fssFalls == 1 && fssRises == 1, "R8", "select pulses",
          fssFalls * 16 + fssRises, 17);
    popWord(replyOf(c, effN), "R6");
    @(negedge clk);
    check(rxEmpty, "R5", "single reply only", int'(rxEmpty), 1);
  endtask

  // Three chained frames: R9
  task automatic testContinuous();
    logic [7:0] cmds [3];
    cmds[0] = 8'h5C; cmds[1] = 8'hE1; cmds[2] = 8'h07;
    configure(4, 12, 1'b1);
    for (int i = 0; i < 3; i++) pushCmd(cmds[i]);
    waitFrames(3);
    check(fssFalls == 1, "R9", "select falls in chain", fssFalls, 1);
    check(fssRises == 1, "R9", "select rises in chain", fssRises, 1);
    for (int i = 0; i < 3; i++) begin
      check(cmdLog[i] == cmds[i], "R9", "chained command", int'(cmdLog[i]), int'(cmds[i]));
      popWord(replyOf(cmds[i], 12), "R9");
    end
  endtask

  // Continuous with nothing queued closes like single: R10
  task automatic testContinuousLone();
    configure(6, 5, 1'b1);
    pushCmd(8'h9B);
    waitFrames(1);
    check(fssRises == 1, "R10", "lone frame closes", fssRises, 1);
    check(cmdLog[0] == 8'h9B, "R10", "lone command", int'(cmdLog[0]), 8'h9B);
    popWord(replyOf(8'h9B, 5), "R10");
  endtask

  // Overfill both FIFOs: R11
  task automatic testFull();
    configure(2, 4, 1'b0);
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      txPush = 1'b1;
      txData = 8'(8'h10 + i);
      @(negedge clk);
    end
    txPush = 1'b0;
    check(txFull, "R11", "tx full after burst", int'(txFull), 1);
    waitFrames(9);
    repeat (40) @(negedge clk);
    check(nLog == 9, "R11", "frames sent after overfill", nLog, 9);
    for (int i = 0; i < 9; i++)
      check(cmdLog[i] == 8'(8'h10 + i), "R11", "queued order",
            int'(cmdLog[i]), 8'h10 + i);
    check(rxFull, "R11", "rx full", int'(rxFull), 1);
    for (int i = 0; i < 8; i++) popWord(replyOf(8'(8'h10 + i), 4), "R11");
    @(negedge clk);
    check(rxEmpty, "R11", "ninth reply dropped", int'(rxEmpty), 1);
    rxPop = 1'b1;  // pop while empty
    @(negedge clk);
    rxPop = 1'b0;
    check(rxEmpty && !rxFull, "R11", "pop on empty", {rxFull, rxEmpty}, 1);
    check(txEmpty, "R11", "tx drained", int'(txEmpty), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSingle(4, 8, 8'hA5);
    testSingle(2, 4, 8'h3C);
    testSingle(6, 16, 8'hF0);
    testSingle(4, 2, 8'h81);    // R6 clamp up to 4
    testSingle(4, 20, 8'h6E);   // R6 clamp down to 16
    testContinuous();
    testContinuousLone();
    testFull();
    testSingle(4, 9, 8'hC3);    // pointers intact after empty pop (R11)
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule